// File: doc/BRIEF.md
# USB Transceiver Status Register Bank

This block is a small set of byte-wide registers that sits beside the line and session logic of a USB transceiver. Software reaches it through a plain register port: an address, a read strobe, a write strobe and a write byte. Read data comes back registered, one clock after the strobe, and holds until the next read.

The bank holds three things. An event latch records edges on five status inputs: host disconnect, VBUS valid, session valid, session end and ID ground. Which edges count is chosen per input by two enable masks, one for rising and one for falling. The latch bits stay set until the latch register is read, and that read clears them all. A read-only debug register shows the present two-bit line state. A scratch byte has no effect on anything else. Software can load it, OR bits into it, or clear bits in it through three aliased addresses, and can read it back at any of them.

The status inputs must already be synchronous to the register clock. Edges are found by comparing each input with a registered copy of itself. That copy is loaded on the first clock after reset, and no event is reported on that clock.

Top module: `psr_bank`

## Requirements
- R1: After reset, `reg_rdata` is 00h, and the first reads of the latch (14h) and scratch (16h) return 00h.
- R2: An event on status bit i sets latch bit i. An event is a 0-to-1 change while `rise_en[i]` is 1, or a 1-to-0 change while `fall_en[i]` is 1. The bit order is: 0 host disconnect, 1 VBUS valid, 2 session valid, 3 session end, 4 ID ground. A change on the input shows in a latch read started on the next clock.
- R3: Latch bits are sticky. A read at address 14h returns the latch in bits 4..0, and every latch bit is 0 after that read.
- R4: If an event arrives on the same clock as a latch read, the read returns the old value and the new event stays latched.
- R5: Bits 7..5 of a latch read are always 0.
- R6: A read at address 15h returns line_state[1] in bit 1 and line_state[0] in bit 0, sampled on the read clock. Bits 7..2 are 0.
- R7: A write at 16h loads the scratch byte. Reads at 16h, 17h and 18h all return the scratch byte.
- R8: A write at 17h ORs the write byte into the scratch byte.
- R9: A write at 18h clears each scratch bit whose write-byte bit is 1, and leaves the other bits unchanged.
- R10: Writes to 14h, 15h or any unmapped address change neither the latch nor the scratch byte. Scratch writes do not touch the latch.
- R11: A read at an unmapped address returns 00h. `reg_rdata` changes only on the clock after a read strobe.
- R12: Input levels present at reset release produce no event on the first clock after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 6 | Register address |
| reg_rd | input | 1 | Read strobe, one cycle |
| reg_wr | input | 1 | Write strobe, one cycle |
| reg_wdata | input | 8 | Write byte |
| reg_rdata | output | 8 | Registered read byte |
| status_in | input | 5 | Synchronized status inputs (bit order per R2) |
| rise_en | input | 5 | Per-input rising-edge enable |
| fall_en | input | 5 | Per-input falling-edge enable |
| line_state | input | 2 | Present line state |

## Verification
The bound checker checks the following on every cycle:
- reserved and upper debug bits read as zero;
- a latch read returns the stored value and leaves only that cycle's events;
- latch bits never drop without a read;
- set and clear aliases force their bits;
- debug reads follow the line state;
- unmapped reads return zero;
- read data holds between strobes.

Whether an event is raised on exactly the enabled edges of the right input, with the R2 bit order, is shown only by the bench's scenarios. The same holds for the suppressed edge after reset, the event-and-clear collision, and the ignored writes to the latch and debug addresses. The bench compares these against its own model under random status, mask and access traffic.

// File: rtl/psr_pkg.sv
package psr_pkg;

   // Scratch update operations selected by the aliased write addresses
   typedef enum logic [1:0] {
      SCR_LOAD = 2'd0,
      SCR_SET  = 2'd1,
      SCR_CLR  = 2'd2
   } scr_op_e;

   // Event latch bit order (read by software, so positions are fixed)
   localparam int EVT_HOST_DISC = 0;
   localparam int EVT_VBUS_OK   = 1;
   localparam int EVT_SESS_OK   = 2;
   localparam int EVT_SESS_LOW  = 3;
   localparam int EVT_ID_GND    = 4;
   localparam int EVT_COUNT     = 5;

endpackage

// File: rtl/psr_edge_latch.sv
module psr_edge_latch #(
   parameter int N_EVT = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_EVT-1:0] status_i,
   input  logic [N_EVT-1:0] rise_en_i,
   input  logic [N_EVT-1:0] fall_en_i,
   input  logic             clear_i,
   output logic [N_EVT-1:0] event_o,
   output logic [N_EVT-1:0] latch_o
);

   logic [N_EVT-1:0] prev_q;
   logic             primed_q;
   logic [N_EVT-1:0] latch_q;

   // Copy of the inputs from the last clock; primed marks that it is valid
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q   <= '0;
         primed_q <= 1'b0;
      end else begin
         prev_q   <= status_i;
         primed_q <= 1'b1;
      end
   end

   // One edge detector per input
   for (genvar g = 0; g < N_EVT; g++) begin : g_edge
      logic rise_w, fall_w;
      assign rise_w     = status_i[g] & ~prev_q[g];
      assign fall_w     = ~status_i[g] & prev_q[g];
      assign event_o[g] = primed_q & ((rise_w & rise_en_i[g]) | (fall_w & fall_en_i[g]));
   end

   // The clear wipes the old contents; events of the same cycle survive it
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) latch_q <= '0;
      else if (clear_i) latch_q <= event_o;
      else latch_q <= latch_q | event_o;
   end

   assign latch_o = latch_q;

endmodule

// File: rtl/psr_scratch.sv
module psr_scratch
   import psr_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_i,
   input  scr_op_e           op_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [DATA_W-1:0] q_o
);

   logic [DATA_W-1:0] q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q <= '0;
      end else if (wr_i) begin
         case (op_i)
            SCR_LOAD: q <= wdata_i;
            SCR_SET:  q <= q | wdata_i;
            SCR_CLR:  q <= q & ~wdata_i;
            default:  q <= q;
         endcase
      end
   end

   assign q_o = q;

endmodule

// File: rtl/psr_rd_port.sv
module psr_rd_port #(
   parameter int DATA_W = 8,
   parameter int N_EVT  = 5,
   parameter int N_LS   = 2,
   parameter int ADDR_W = 6,
   parameter logic [ADDR_W-1:0] A_LATCH = 'h14,
   parameter logic [ADDR_W-1:0] A_DEBUG = 'h15,
   parameter logic [ADDR_W-1:0] A_SCR0  = 'h16,
   parameter logic [ADDR_W-1:0] A_SCR1  = 'h17,
   parameter logic [ADDR_W-1:0] A_SCR2  = 'h18
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [N_EVT-1:0]  latch_i,
   input  logic [N_LS-1:0]   ls_i,
   input  logic [DATA_W-1:0] scr_i,
   output logic [DATA_W-1:0] rdata_o
);

   logic [DATA_W-1:0] latch_ext, ls_ext, sel;
   logic [DATA_W-1:0] rdata_q;

   always_comb begin
      latch_ext              = '0;
      latch_ext[N_EVT-1:0]   = latch_i;
      ls_ext                 = '0;
      ls_ext[N_LS-1:0]       = ls_i;
   end

   always_comb begin
      if (addr_i == A_LATCH) sel = latch_ext;
      else if (addr_i == A_DEBUG) sel = ls_ext;
      else if (addr_i == A_SCR0 || addr_i == A_SCR1 || addr_i == A_SCR2) sel = scr_i;
      else sel = '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rdata_q <= '0;
      else if (rd_i) rdata_q <= sel;
   end

   assign rdata_o = rdata_q;

endmodule

// File: rtl/psr_bank.sv
module psr_bank
   import psr_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 6,
   parameter int N_EVT  = EVT_COUNT,
   parameter int N_LS   = 2,
   parameter logic [ADDR_W-1:0] A_LATCH = 'h14,
   parameter logic [ADDR_W-1:0] A_DEBUG = 'h15,
   parameter logic [ADDR_W-1:0] A_SCR0  = 'h16,
   parameter logic [ADDR_W-1:0] A_SCR1  = 'h17,
   parameter logic [ADDR_W-1:0] A_SCR2  = 'h18
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic              reg_rd,
   input  logic              reg_wr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic [N_EVT-1:0]  status_in,
   input  logic [N_EVT-1:0]  rise_en,
   input  logic [N_EVT-1:0]  fall_en,
   input  logic [N_LS-1:0]   line_state
);

   // Elaboration checks on the parameter set
   if (N_EVT >= DATA_W) begin : g_bad_evt
      $error("psr_bank: N_EVT must leave reserved bits in the byte");
   end
   if (N_LS >= DATA_W || N_LS < 1) begin : g_bad_ls
      $error("psr_bank: N_LS out of range");
   end
   if (A_SCR0 == A_LATCH || A_SCR1 == A_LATCH || A_SCR2 == A_LATCH ||
       A_SCR0 == A_DEBUG || A_SCR1 == A_DEBUG || A_SCR2 == A_DEBUG ||
       A_LATCH == A_DEBUG) begin : g_bad_map
      $error("psr_bank: register addresses overlap");
   end

   logic             latch_clr;
   logic             scr_wr;
   scr_op_e          scr_op;
   logic [N_EVT-1:0] evt_vec;
   logic [N_EVT-1:0] latch_q;
   logic [DATA_W-1:0] scr_q;

   // Address decode
   assign latch_clr = reg_rd && (reg_addr == A_LATCH);

   always_comb begin
      scr_wr = 1'b0;
      scr_op = SCR_LOAD;
      if (reg_wr) begin
         if (reg_addr == A_SCR0) begin
            scr_wr = 1'b1;
            scr_op = SCR_LOAD;
         end else if (reg_addr == A_SCR1) begin
            scr_wr = 1'b1;
            scr_op = SCR_SET;
         end else if (reg_addr == A_SCR2) begin
            scr_wr = 1'b1;
            scr_op = SCR_CLR;
         end
      end
   end

   psr_edge_latch #(.N_EVT(N_EVT)) u_latch (
      .clk       (clk),
      .rst_n     (rst_n),
      .status_i  (status_in),
      .rise_en_i (rise_en),
      .fall_en_i (fall_en),
      .clear_i   (latch_clr),
      .event_o   (evt_vec),
      .latch_o   (latch_q)
   );

   psr_scratch #(.DATA_W(DATA_W)) u_scr (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_i    (scr_wr),
      .op_i    (scr_op),
      .wdata_i (reg_wdata),
      .q_o     (scr_q)
   );

   psr_rd_port #(
      .DATA_W (DATA_W), .N_EVT(N_EVT), .N_LS(N_LS), .ADDR_W(ADDR_W),
      .A_LATCH(A_LATCH), .A_DEBUG(A_DEBUG),
      .A_SCR0 (A_SCR0), .A_SCR1(A_SCR1), .A_SCR2(A_SCR2)
   ) u_rd (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_i    (reg_rd),
      .addr_i  (reg_addr),
      .latch_i (latch_q),
      .ls_i    (line_state),
      .scr_i   (scr_q),
      .rdata_o (reg_rdata)
   );

endmodule

// File: rtl/psr_bank_chk.sv
module psr_bank_chk #(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 6,
   parameter int N_EVT  = 5,
   parameter int N_LS   = 2,
   parameter logic [ADDR_W-1:0] A_LATCH = 'h14,
   parameter logic [ADDR_W-1:0] A_DEBUG = 'h15,
   parameter logic [ADDR_W-1:0] A_SCR0  = 'h16,
   parameter logic [ADDR_W-1:0] A_SCR1  = 'h17,
   parameter logic [ADDR_W-1:0] A_SCR2  = 'h18
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] reg_addr,
   input logic              reg_rd,
   input logic              reg_wr,
   input logic [DATA_W-1:0] reg_wdata,
   input logic [DATA_W-1:0] reg_rdata,
   input logic [N_LS-1:0]   line_state,
   input logic [N_EVT-1:0]  evt_vec,
   input logic [N_EVT-1:0]  latch_q,
   input logic [DATA_W-1:0] scr_q
);

   logic rd_latch, rd_debug, rd_scr, rd_unmapped;
   assign rd_latch    = reg_rd && reg_addr == A_LATCH;
   assign rd_debug    = reg_rd && reg_addr == A_DEBUG;
   assign rd_scr      = reg_rd && (reg_addr == A_SCR0 || reg_addr == A_SCR1 || reg_addr == A_SCR2);
   assign rd_unmapped = reg_rd && !rd_latch && !rd_debug && !rd_scr;

   // R3: latch read returns the stored value
   p_rd_latch_value_r3: assert property (@(posedge clk) disable iff (!rst_n)
      rd_latch |=> reg_rdata[N_EVT-1:0] == $past(latch_q));

   // R3, R4: after a clearing read only that cycle's events remain
   p_clear_keeps_new_r4: assert property (@(posedge clk) disable iff (!rst_n)
      rd_latch |=> (latch_q & ~$past(evt_vec)) == '0);

   // R3: latch bits never drop without a read
   p_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_latch |=> ($past(latch_q) & ~latch_q) == '0);

   // R5: reserved latch bits read 0
   p_rsv_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      rd_latch |=> reg_rdata[DATA_W-1:N_EVT] == '0);

   // R6: debug read follows the line state
   p_debug_r6: assert property (@(posedge clk) disable iff (!rst_n)
      rd_debug |=> reg_rdata[N_LS-1:0] == $past(line_state) && reg_rdata[DATA_W-1:N_LS] == '0);

   // R7: scratch reads at any alias return the byte
   p_scr_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
      rd_scr |=> reg_rdata == $past(scr_q));

   // R8: set alias forces the written ones
   p_scr_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == A_SCR1) |=> (scr_q & $past(reg_wdata)) == $past(reg_wdata));

   // R9: clear alias forces the written ones to zero
   p_scr_clr_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == A_SCR2) |=> (scr_q & $past(reg_wdata)) == '0);

   // R11: unmapped reads return zero
   p_unmapped_r11: assert property (@(posedge clk) disable iff (!rst_n)
      rd_unmapped |=> reg_rdata == '0);

   // R11: read data holds without a strobe
   p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_rd |=> $stable(reg_rdata));

endmodule

bind psr_bank psr_bank_chk #(
   .DATA_W(DATA_W), .ADDR_W(ADDR_W), .N_EVT(N_EVT), .N_LS(N_LS),
   .A_LATCH(A_LATCH), .A_DEBUG(A_DEBUG),
   .A_SCR0(A_SCR0), .A_SCR1(A_SCR1), .A_SCR2(A_SCR2)
) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .reg_addr   (reg_addr),
   .reg_rd     (reg_rd),
   .reg_wr     (reg_wr),
   .reg_wdata  (reg_wdata),
   .reg_rdata  (reg_rdata),
   .line_state (line_state),
   .evt_vec    (evt_vec),
   .latch_q    (latch_q),
   .scr_q      (scr_q)
);

// File: tb/psr_bank_tb.sv
module psr_bank_tb_top;

   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [5:0] reg_addr = '0;
   logic       reg_rd = 1'b0;
   logic       reg_wr = 1'b0;
   logic [7:0] reg_wdata = '0;
   logic [7:0] reg_rdata;
   logic [4:0] status_in = '0;
   logic [4:0] rise_en = '0;
   logic [4:0] fall_en = '0;
   logic [1:0] line_state = '0;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   // Bench model of the register state
   logic [4:0] m_latch = '0;
   logic [4:0] m_prev = '0;
   logic       m_primed = 1'b0;
   logic [7:0] m_scr = '0;
   logic [7:0] m_rdata = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   psr_bank dut_i (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_rd(reg_rd),
      .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .status_in(status_in), .rise_en(rise_en), .fall_en(fall_en),
      .line_state(line_state)
   );

   function automatic logic [7:0] exp_read(input logic [5:0] a);
      case (a)
         6'h14:               return {3'b000, m_latch};
         6'h15:               return {6'b0, line_state};
         6'h16, 6'h17, 6'h18: return m_scr;
         default:             return 8'h00;
      endcase
   endfunction

   function automatic string tag_for(input logic rd, input logic [5:0] a);
      if (!rd) return "R11 hold";
      case (a)
         6'h14:               return "R3 latch read";
         6'h15:               return "R6 debug read";
         6'h16, 6'h17, 6'h18: return "R7 scratch read";
         default:             return "R11 unmapped read";
      endcase
   endfunction

   task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
      end
   endtask

   // One clock: drive at the negedge, update the model at the posedge, check at the next negedge
   task automatic step(input logic rd, input logic wr, input logic [5:0] a,
                       input logic [7:0] wd, input string tag);
      logic [4:0] evt;
      reg_rd = rd; reg_wr = wr; reg_addr = a; reg_wdata = wd;
      @(posedge clk);
      evt = m_primed ? ((status_in & ~m_prev & rise_en) | (~status_in & m_prev & fall_en)) : 5'b0;
      if (rd) m_rdata = exp_read(a);
      if (rd && a == 6'h14) m_latch = evt;
      else m_latch = m_latch | evt;
      if (wr) begin
         case (a)
            6'h16: m_scr = wd;
            6'h17: m_scr = m_scr | wd;
            6'h18: m_scr = m_scr & ~wd;
            default: ;
         endcase
      end
      m_prev = status_in;
      m_primed = 1'b1;
      @(negedge clk);
      reg_rd = 1'b0; reg_wr = 1'b0;
      check(reg_rdata, m_rdata, (tag == "") ? tag_for(rd, a) : tag);
   endtask

   initial begin
      void'($urandom(32'd20240611));
      // R12: inputs high and enabled across reset release
      status_in = 5'h1F; rise_en = 5'h1F; fall_en = 5'h1F;
      repeat (3) @(negedge clk);
      check(reg_rdata, 8'h00, "R1 rdata at reset");
      rst_n = 1'b1;
      step(1'b0, 1'b0, 6'h00, 8'h00, "R1 idle after reset");
      step(1'b1, 1'b0, 6'h14, 8'h00, "R12 no event after reset");
      check(reg_rdata, 8'h00, "R1 latch reads 00h");
      step(1'b1, 1'b0, 6'h16, 8'h00, "R1 scratch reads 00h");

      // R2: falling edge on VBUS valid only (bit 1)
      rise_en = 5'h00; fall_en = 5'b00010;
      status_in = 5'b11101;
      step(1'b0, 1'b0, 6'h00, 8'h00, "");
      step(1'b1, 1'b0, 6'h14, 8'h00, "R2 falling edge");
      check(reg_rdata, 8'h02, "R2 bit1 falling edge latched");
      // R2: rising edge masked off, no event
      status_in = 5'h1F;
      step(1'b0, 1'b0, 6'h00, 8'h00, "");
      step(1'b1, 1'b0, 6'h14, 8'h00, "R2 masked rise");
      check(reg_rdata, 8'h00, "R2 masked rising edge ignored");

      // R4: event on the same clock as the clearing read
      rise_en = 5'h1F; fall_en = 5'h00;
      status_in = 5'h00;
      step(1'b0, 1'b0, 6'h00, 8'h00, "");
      status_in = 5'b00001;
      step(1'b0, 1'b0, 6'h00, 8'h00, "");
      status_in = 5'b10001;
      step(1'b1, 1'b0, 6'h14, 8'h00, "R4 collision read");
      check(reg_rdata, 8'h01, "R4 old value returned");
      step(1'b1, 1'b0, 6'h14, 8'h00, "R4 event kept");
      check(reg_rdata, 8'h10, "R4 new event kept after clear");

      // R10: writes to latch and debug addresses ignored
      status_in = 5'b00011;
      step(1'b0, 1'b0, 6'h00, 8'h00, "");
      step(1'b0, 1'b1, 6'h14, 8'hFF, "");
      step(1'b0, 1'b1, 6'h15, 8'hFF, "");
      step(1'b0, 1'b1, 6'h3F, 8'hFF, "");
      step(1'b1, 1'b0, 6'h14, 8'h00, "R10 latch after ignored write");
      check(reg_rdata, 8'h02, "R10 latch unchanged by writes");
      step(1'b1, 1'b0, 6'h16, 8'h00, "R10 scratch after ignored write");
      check(reg_rdata, 8'h00, "R10 scratch unchanged by writes");

      // R7, R8, R9 scratch aliases
      step(1'b0, 1'b1, 6'h16, 8'hA5, "");
      step(1'b1, 1'b0, 6'h18, 8'h00, "R7 load read via alias");
      check(reg_rdata, 8'hA5, "R7 load A5h");
      step(1'b0, 1'b1, 6'h17, 8'h0F, "");
      step(1'b1, 1'b0, 6'h17, 8'h00, "R8 set");
      check(reg_rdata, 8'hAF, "R8 set 0Fh");
      step(1'b0, 1'b1, 6'h18, 8'h81, "");
      step(1'b1, 1'b0, 6'h16, 8'h00, "R9 clear");
      check(reg_rdata, 8'h2E, "R9 clear 81h");
      step(1'b1, 1'b0, 6'h14, 8'h00, "R10 latch after scratch writes");
      check(reg_rdata, 8'h00, "R10 scratch writes leave latch");

      // R6 debug, R5 reserved, R11 unmapped
      line_state = 2'b10;
      step(1'b1, 1'b0, 6'h15, 8'h00, "R6 debug 10b");
      check(reg_rdata, 8'h02, "R6 line state 10b");
      step(1'b1, 1'b0, 6'h2A, 8'h00, "R11 unmapped");
      check(reg_rdata, 8'h00, "R11 unmapped reads 00h");

      // Random traffic
      for (int i = 0; i < 4000; i++) begin
         logic [31:0] r;
         logic [5:0]  a;
         r = $urandom();
         if (r[3:0] == 4'hF) status_in = r[8:4];
         if (r[11:9] == 3'h0) rise_en = r[16:12];
         if (r[11:9] == 3'h1) fall_en = r[16:12];
         if (r[19:17] == 3'h0) line_state = r[21:20];
         r = $urandom();
         a = (r[2:0] == 3'd7) ? r[8:3] : 6'h13 + 6'(r[2:0]);
         step(r[9], r[10], a, r[18:11], "");
         // R5: reserved bits checked on every latch read
         if (r[9] && a == 6'h14) check({reg_rdata[7:5], 5'b0}, 8'h00, "R5 reserved bits");
      end

      if (!done) begin
         done = 1'b1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule